// File: doc/BRIEF.md
# Bus data parity error handler

This block sits on one side of a two-port parallel bus bridge and watches the data parity of every completed data phase. A phase completes when the initiator-ready and target-ready strobes are both low on the same rising clock edge. The block captures the 32-bit address/data word and the 4 byte-enable lines on that edge. One clock later it checks them against the parity bit, because the bus delivers parity one cycle behind the data it covers.

A parity error never stops the transfer: there is no abort and no retry. On a configuration write aimed at the bridge's own registers, the register write strobe still fires with the received data. On read data coming back across the bridge, the word is still accepted. When parity is bad, the block can pulse an active-low error output and sets sticky status bits. Each word also gets a bad-parity tag in a small ring that mirrors the bridge's prefetch buffer. The other port reads that tag when it forwards the word, so the requester receives the word with its parity still wrong. A flush of the prefetch buffer drops every tag, so discarded words never produce a bad-parity completion.

Top module: `par_err_handler`

## Requirements
- R1: A data phase is counted only when `irdy_n` and `trdy_n` are both 0 at the same rising edge. With either one high there is no check, no write strobe, no status change and no ring entry.
- R2: Parity is even over the 32 data bits, the 4 byte-enable bits and `bus_par`. `bus_par` is sampled on the edge one clock after the edge that completed the phase. A single flipped bit in any of these 37 positions is an error.
- R3: For an error in the phase completed at edge k, `perr_n` is 0 from edge k+1 to edge k+2. It is low for exactly one clock per erroneous phase, and errors in back-to-back phases give low outputs in consecutive clocks.
- R4: `perr_n` is driven low only when the response enable for the phase's kind is 1: `cfg_resp_en` when `xfer_cfg`=1 (configuration write), `rd_resp_en` when `xfer_cfg`=0 (read data). The enable is sampled on the same edge as `bus_par`.
- R5: `stat_dpe` is set on every parity error, whatever the enables are.
- R6: `stat_mdpd` is set only by a read-data parity error while `rd_resp_en` is 1. Configuration-write errors never set it.
- R7: Both status bits are sticky. Writing `stat_clr_we`=1 with `stat_clr[0]`=1 clears `stat_dpe`, and with `stat_clr[1]`=1 clears `stat_mdpd`. A new error on the same edge wins over the clear.
- R8: A completed configuration write pulses `cfg_we` for one clock after edge k, with `cfg_wdata` equal to the captured word, whether or not parity is good.
- R9: Each completed read phase enters the ring on the parity-check edge, in order. `fwd_avail` shows a word is waiting, and `fwd_bad` gives its tag (1 = bad parity, to be forwarded). `fwd_pop` removes it.
- R10: `ring_flush` empties the ring and clears all tags. A read word whose parity check falls on the same edge is discarded too, although its error is still reported through `perr_n` and the status bits.
- R11: While the ring holds DEPTH words and no pop happens on the same edge, further read words are dropped and the occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad | input | 32 | Address/data lines |
| bus_cbe | input | 4 | Byte-enable lines |
| bus_par | input | 1 | Even parity bit, one clock behind the data |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| xfer_cfg | input | 1 | 1 = configuration write to own registers, 0 = read data return |
| cfg_resp_en | input | 1 | Response enable for configuration writes |
| rd_resp_en | input | 1 | Response enable for read data |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr | input | 2 | Bits to clear: [0] detected, [1] reported read error |
| ring_flush | input | 1 | Discard all buffered words and their tags |
| fwd_pop | input | 1 | Other port consumes the head word |
| perr_n | output | 1 | Parity error output, active low |
| stat_dpe | output | 1 | Sticky detected-parity-error bit |
| stat_mdpd | output | 1 | Sticky reported read parity error bit |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_wdata | output | 32 | Configuration register write data |
| fwd_avail | output | 1 | A buffered word is waiting |
| fwd_bad | output | 1 | Head word carries bad parity |

## Verification
The hardest case to reach is a flush that lands on the exact edge where a read word's late parity is checked. The error must still be reported there, while the word and its tag disappear. The bench reaches it by completing a read phase and then raising the flush together with a wrong parity bit in the following clock. It checks that the ring is empty afterwards while the error output and the detected bit still respond. The same one-clock offset is used to put a status clear on the same edge as a new error, and to place two erroneous phases back to back.

// File: rtl/par_pkg.sv
package par_pkg;

  typedef enum logic {
    KIND_RD  = 1'b0,
    KIND_CFG = 1'b1
  } phase_kind_e;

  localparam int STAT_DPE_BIT  = 0;
  localparam int STAT_MDPD_BIT = 1;
  localparam int STAT_W        = 2;

endpackage

// File: rtl/par_capture.sv
module par_capture
  import par_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [BE_W-1:0]   bus_cbe,
  input  logic              bus_par,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              xfer_cfg,
  output logic              phase_done,
  output logic              chk_vld,
  output phase_kind_e       chk_kind,
  output logic              par_err,
  output logic              cfg_we,
  output logic [DATA_W-1:0] cfg_wdata
);

  // odd number of ones over data, enables and parity means an error
  function automatic logic parity_bad(input logic [DATA_W-1:0] ad,
                                      input logic [BE_W-1:0]   be,
                                      input logic              p);
    return ^{ad, be, p};
  endfunction

  logic [DATA_W-1:0] cap_ad;
  logic [BE_W-1:0]   cap_be;

  assign phase_done = ~irdy_n & ~trdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld  <= 1'b0;
      chk_kind <= KIND_RD;
      cap_ad   <= '0;
      cap_be   <= '0;
    end else begin
      chk_vld <= phase_done;
      if (phase_done) begin
        chk_kind <= xfer_cfg ? KIND_CFG : KIND_RD;
        cap_ad   <= bus_ad;
        cap_be   <= bus_cbe;
      end
    end
  end

  assign par_err   = chk_vld & parity_bad(cap_ad, cap_be, bus_par);
  assign cfg_we    = chk_vld & (chk_kind == KIND_CFG);
  assign cfg_wdata = cap_ad;

  a_r8_cfg_we_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> ($past(phase_done) && $past(xfer_cfg)));

  a_r1_check_needs_phase: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(phase_done));

endmodule

// File: rtl/par_report.sv
module par_report
  import par_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_err,
  input  phase_kind_e       chk_kind,
  input  logic              cfg_resp_en,
  input  logic              rd_resp_en,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr,
  output logic              perr_n,
  output logic              stat_dpe,
  output logic              stat_mdpd
);

  logic report_en;
  logic rd_reported;
  logic perr_q;
  logic clr_dpe;
  logic clr_mdpd;

  assign report_en   = (chk_kind == KIND_CFG) ? cfg_resp_en : rd_resp_en;
  assign rd_reported = par_err & (chk_kind == KIND_RD) & rd_resp_en;
  assign clr_dpe     = stat_clr_we & stat_clr[STAT_DPE_BIT];
  assign clr_mdpd    = stat_clr_we & stat_clr[STAT_MDPD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q    <= 1'b0;
      stat_dpe  <= 1'b0;
      stat_mdpd <= 1'b0;
    end else begin
      perr_q <= par_err & report_en;
      if (par_err)      stat_dpe <= 1'b1;
      else if (clr_dpe) stat_dpe <= 1'b0;
      if (rd_reported)   stat_mdpd <= 1'b1;
      else if (clr_mdpd) stat_mdpd <= 1'b0;
    end
  end

  assign perr_n = ~perr_q;

  a_r5_err_sets_dpe: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> stat_dpe);

  a_r6_mdpd_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_mdpd) |-> ($past(rd_resp_en) && $past(par_err)));

  a_r7_dpe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_dpe && !clr_dpe) |=> stat_dpe);

  a_r4_perr_implies_dpe: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> stat_dpe);

endmodule

// File: rtl/par_tag_ring.sv
module par_tag_ring #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_bad,
  input  logic flush,
  input  logic pop,
  output logic avail,
  output logic head_bad
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DEPTH-1:0] tag;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_pop;
  logic             accept;

  assign avail    = (cnt != '0);
  assign head_bad = avail & tag[rd_ptr];
  assign do_pop   = pop & avail & ~flush;
  assign accept   = push & ~flush & ((cnt != FULL_CNT) | do_pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     tag[i] <= 1'b0;
      else if (flush)                                 tag[i] <= 1'b0;
      else if (accept && wr_ptr == PTR_W'(i))         tag[i] <= push_bad;
      else if (do_pop && rd_ptr == PTR_W'(i))         tag[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop) rd_ptr <= ptr_next(rd_ptr);
      case ({accept, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !avail);

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  a_r9_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !accept) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/par_err_handler.sv
module par_err_handler
  import par_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [BE_W-1:0]   bus_cbe,
  input  logic              bus_par,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              xfer_cfg,
  input  logic              cfg_resp_en,
  input  logic              rd_resp_en,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr,
  input  logic              ring_flush,
  input  logic              fwd_pop,
  output logic              perr_n,
  output logic              stat_dpe,
  output logic              stat_mdpd,
  output logic              cfg_we,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              fwd_avail,
  output logic              fwd_bad
);

  logic        phase_done;
  logic        chk_vld;
  phase_kind_e chk_kind;
  logic        par_err;
  logic        rd_push;

  par_capture #(.DATA_W(DATA_W), .BE_W(BE_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ad     (bus_ad),
    .bus_cbe    (bus_cbe),
    .bus_par    (bus_par),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .xfer_cfg   (xfer_cfg),
    .phase_done (phase_done),
    .chk_vld    (chk_vld),
    .chk_kind   (chk_kind),
    .par_err    (par_err),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata)
  );

  par_report u_report (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_err     (par_err),
    .chk_kind    (chk_kind),
    .cfg_resp_en (cfg_resp_en),
    .rd_resp_en  (rd_resp_en),
    .stat_clr_we (stat_clr_we),
    .stat_clr    (stat_clr),
    .perr_n      (perr_n),
    .stat_dpe    (stat_dpe),
    .stat_mdpd   (stat_mdpd)
  );

  assign rd_push = chk_vld & (chk_kind == KIND_RD);

  par_tag_ring #(.DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rd_push),
    .push_bad (par_err),
    .flush    (ring_flush),
    .pop      (fwd_pop),
    .avail    (fwd_avail),
    .head_bad (fwd_bad)
  );

  a_r3_perr_two_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(phase_done, 2));

  a_r10_flush_drops_head: assert property (@(posedge clk) disable iff (!rst_n)
    ring_flush |=> !fwd_bad);

endmodule

// File: tb/par_err_handler_tb_top.sv
module par_err_handler_tb_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe = '0;
  logic        bus_par = 1'b0;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic        xfer_cfg = 1'b0;
  logic        cfg_resp_en = 1'b0;
  logic        rd_resp_en = 1'b0;
  logic        stat_clr_we = 1'b0;
  logic [1:0]  stat_clr = '0;
  logic        ring_flush = 1'b0;
  logic        fwd_pop = 1'b0;
  logic        perr_n, stat_dpe, stat_mdpd, cfg_we, fwd_avail, fwd_bad;
  logic [31:0] cfg_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  par_err_handler #(.DATA_W(32), .BE_W(4), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe), .bus_par(bus_par),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .xfer_cfg(xfer_cfg), .cfg_resp_en(cfg_resp_en),
    .rd_resp_en(rd_resp_en), .stat_clr_we(stat_clr_we), .stat_clr(stat_clr),
    .ring_flush(ring_flush), .fwd_pop(fwd_pop), .perr_n(perr_n), .stat_dpe(stat_dpe),
    .stat_mdpd(stat_mdpd), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fwd_avail(fwd_avail), .fwd_bad(fwd_bad)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic even_par(input logic [31:0] a, input logic [3:0] b);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += b[i];
    return (ones % 2) == 1;
  endfunction

  task automatic clear_status();
    stat_clr_we = 1'b1; stat_clr = 2'b11;
    tick();
    stat_clr_we = 1'b0; stat_clr = 2'b00;
  endtask

  task automatic flush_ring();
    ring_flush = 1'b1;
    tick();
    ring_flush = 1'b0;
  endtask

  // one phase; flip_pos 0..31 data bit, 32..35 byte enable, 36 parity, -1 none
  task automatic run_phase(input string req, input logic [31:0] ad, input logic [3:0] be,
                           input logic cfg, input int flip_pos, input logic cen,
                           input logic ren, input logic ir_n, input logic tr_n);
    logic [31:0] sad = ad;
    logic [3:0]  sbe = be;
    logic        p = even_par(ad, be);
    logic        done = !ir_n && !tr_n;
    logic        err, rep, dpe0, mdpd0;
    if (flip_pos >= 0 && flip_pos < 32) sad[flip_pos] = ~sad[flip_pos];
    else if (flip_pos >= 32 && flip_pos < 36) sbe[flip_pos-32] = ~sbe[flip_pos-32];
    else if (flip_pos == 36) p = ~p;
    err = done && (flip_pos >= 0);
    rep = err && (cfg ? cen : ren);
    dpe0 = stat_dpe; mdpd0 = stat_mdpd;
    bus_ad = sad; bus_cbe = sbe; xfer_cfg = cfg; irdy_n = ir_n; trdy_n = tr_n;
    tick();
    irdy_n = 1'b1; trdy_n = 1'b1; bus_par = p; cfg_resp_en = cen; rd_resp_en = ren;
    chk({req, " R8 cfg_we"}, cfg_we, done && cfg);
    if (done && cfg) chk({req, " R8 cfg_wdata"}, cfg_wdata, sad);
    tick();
    chk({req, " R3 R4 perr_n low"}, perr_n, !rep);
    chk({req, " R5 stat_dpe"}, stat_dpe, dpe0 | err);
    chk({req, " R6 stat_mdpd"}, stat_mdpd, mdpd0 | (err && !cfg && ren));
    tick();
    chk({req, " R3 perr_n one clock"}, perr_n, 1'b1);
  endtask

  task automatic pop_expect(input string req, input logic exp_bad);
    chk({req, " R9 fwd_avail"}, fwd_avail, 1'b1);
    chk({req, " R9 fwd_bad"}, fwd_bad, exp_bad);
    fwd_pop = 1'b1;
    tick();
    fwd_pop = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("reset perr_n", perr_n, 1'b1);
    chk("reset stat_dpe", stat_dpe, 1'b0);
    chk("reset stat_mdpd", stat_mdpd, 1'b0);
    chk("reset fwd_avail", fwd_avail, 1'b0);
    chk("reset cfg_we", cfg_we, 1'b0);

    // R2: every single-bit position in a read phase, reporting on
    for (int pos = 0; pos < 37; pos++) begin
      clear_status();
      flush_ring();
      run_phase("R2 sweep", 32'hA5C3_0F1E ^ (32'h1 << (pos % 32)), 4'(pos), 1'b0, pos,
                1'b0, 1'b1, 1'b0, 1'b0);
    end
    // good parity under several patterns
    for (int k = 0; k < 8; k++) begin
      clear_status();
      run_phase("R2 good", 32'h1357_9BDF * (k + 1), 4'(k * 3), k[0], -1,
                1'b1, 1'b1, 1'b0, 1'b0);
    end

    // R4 R5 R6: both kinds x all enable combinations
    for (int kind = 0; kind < 2; kind++) begin
      for (int en = 0; en < 4; en++) begin
        clear_status();
        run_phase("R4 enables", 32'hDEAD_0000 + en, 4'hF, kind[0], 36, en[0], en[1],
                  1'b0, 1'b0);
      end
    end

    // R1: incomplete phases are ignored
    clear_status();
    flush_ring();
    run_phase("R1 irdy only", 32'h0000_00FF, 4'h1, 1'b1, 36, 1'b1, 1'b1, 1'b0, 1'b1);
    run_phase("R1 trdy only", 32'h0000_00FF, 4'h1, 1'b0, 36, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R1 no ring entry", fwd_avail, 1'b0);

    // R8: configuration write with bad parity and reporting off still writes
    run_phase("R8 cfg bad", 32'hCAFE_F00D, 4'h3, 1'b1, 5, 1'b0, 1'b0, 1'b0, 1'b0);

    // R7: status clear alone, then clear colliding with a new error
    clear_status();
    run_phase("R7 set", 32'h1, 4'h0, 1'b0, 36, 1'b0, 1'b1, 1'b0, 1'b0);
    stat_clr_we = 1'b1; stat_clr = 2'b01;
    tick();
    stat_clr_we = 1'b0; stat_clr = 2'b00;
    chk("R7 dpe cleared", stat_dpe, 1'b0);
    chk("R7 mdpd kept", stat_mdpd, 1'b1);
    stat_clr_we = 1'b1; stat_clr = 2'b10;
    tick();
    stat_clr_we = 1'b0; stat_clr = 2'b00;
    chk("R7 mdpd cleared", stat_mdpd, 1'b0);
    bus_ad = 32'h7; bus_cbe = 4'h0; xfer_cfg = 1'b0; irdy_n = 1'b0; trdy_n = 1'b0;
    tick();
    irdy_n = 1'b1; trdy_n = 1'b1; bus_par = ~even_par(32'h7, 4'h0);
    stat_clr_we = 1'b1; stat_clr = 2'b11;
    tick();
    stat_clr_we = 1'b0; stat_clr = 2'b00;
    chk("R7 set wins dpe", stat_dpe, 1'b1);
    chk("R7 set wins mdpd", stat_mdpd, 1'b1);

    // R3: back-to-back erroneous phases
    clear_status();
    tick();
    bus_ad = 32'h11; bus_cbe = 4'h0; xfer_cfg = 1'b0; rd_resp_en = 1'b1;
    irdy_n = 1'b0; trdy_n = 1'b0;
    tick();
    bus_par = ~even_par(32'h11, 4'h0);
    bus_ad = 32'h22;
    tick();
    irdy_n = 1'b1; trdy_n = 1'b1;
    bus_par = ~even_par(32'h22, 4'h0);
    chk("R3 b2b first", perr_n, 1'b0);
    tick();
    chk("R3 b2b second", perr_n, 1'b0);
    tick();
    chk("R3 b2b released", perr_n, 1'b1);

    // R9: forwarding order and tags
    flush_ring();
    run_phase("R9 w0", 32'h100, 4'h0, 1'b0, 36, 1'b0, 1'b0, 1'b0, 1'b0);
    run_phase("R9 w1", 32'h200, 4'h0, 1'b0, -1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_phase("R9 w2", 32'h300, 4'h0, 1'b0, 7, 1'b0, 1'b0, 1'b0, 1'b0);
    pop_expect("R9 head0", 1'b1);
    pop_expect("R9 head1", 1'b0);
    pop_expect("R9 head2", 1'b1);
    chk("R9 empty after pops", fwd_avail, 1'b0);

    // R11: overfill, the extra words are dropped
    flush_ring();
    for (int j = 0; j < DEPTH + 2; j++)
      run_phase("R11 fill", 32'h4000 + j, 4'h0, 1'b0, (j % 2 == 1) ? 36 : -1,
                1'b0, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < DEPTH; j++) pop_expect("R11 drain", j[0]);
    chk("R11 extras dropped", fwd_avail, 1'b0);

    // R10: flush of buffered bad words
    run_phase("R10 a", 32'h55, 4'h0, 1'b0, 36, 1'b0, 1'b0, 1'b0, 1'b0);
    run_phase("R10 b", 32'h66, 4'h0, 1'b0, 36, 1'b0, 1'b0, 1'b0, 1'b0);
    flush_ring();
    chk("R10 flushed avail", fwd_avail, 1'b0);
    chk("R10 flushed tag", fwd_bad, 1'b0);

    // R10: flush on the parity-check edge of a bad read word
    clear_status();
    bus_ad = 32'h99; bus_cbe = 4'h2; xfer_cfg = 1'b0; rd_resp_en = 1'b1;
    irdy_n = 1'b0; trdy_n = 1'b0;
    tick();
    irdy_n = 1'b1; trdy_n = 1'b1;
    bus_par = ~even_par(32'h99, 4'h2);
    ring_flush = 1'b1;
    tick();
    ring_flush = 1'b0;
    chk("R10 same-edge avail", fwd_avail, 1'b0);
    chk("R10 same-edge perr_n", perr_n, 1'b0);
    chk("R10 same-edge dpe", stat_dpe, 1'b1);
    tick();
    chk("R10 still empty", fwd_avail, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule